// File: doc/BRIEF.md
# SPI Register Access Master

This block is an SPI master for a peripheral whose registers are 24 bits wide. Each access is one 32-bit full-duplex word. The word carries a write flag, a 6-bit register number and 24 data bits. A single request from local logic can ask for any of the following:

- a read
- a write
- setting bits
- clearing bits
- a masked update
- a short burst of reads or writes, where each entry names its own register

Bit set, bit clear and masked update are carried out as a read followed by a write. The whole pair runs inside one request, so no other traffic can come between the two halves. The write half is dropped when the read half fails.

Local logic presents a request with a valid/ready handshake. It then waits for a one-cycle completion pulse, which carries an error flag and a 24-bit result. For burst reads the words are returned in a flat result vector. On the serial side the block drives the serial clock at one quarter of the system clock, MSB first in mode 0. It also drives an active-high select that drops after every word.

Top module: `spi_regmaster`

## Requirements
- R1: Every word is 32 bits, laid out as follows:
  - Bit 31 is 1 for a write and 0 for a read.
  - Bits 30:25 hold the register number.
  - Bit 24 is 0.
  - Bits 23:0 carry the write data. In a read word these bits are zero.
- R2: The serial clock idles low and has a period of 4 system clocks, giving 32 rising edges per word. MOSI is sent MSB first and changes only on falling edges; MISO is sampled on rising edges. The select is high for exactly 128 system clocks per word and goes low between every two words, including inside a burst.
- R3: A read returns bits 23:0 of the word received on MISO. If the received word is all ones (32 ones), the read is reported as an error.
- R4: A write sends one word and completes with no error and result 0.
- R5: The three read-modify-write operations each send a read word and then a write word to the same register, and each returns the old 24-bit value. The value written is:
  - set bits (op 2): old OR data;
  - clear bits (op 3): old AND NOT data;
  - masked update (op 4): (old AND NOT mask) OR (data AND mask).
- R6: If the read half of a read-modify-write receives an all-ones word, no write word is sent and the request completes with the error flag set.
- R7: A single-register request whose register number is at or above NUM_REGS completes with an error and produces no serial activity.
- R8: A burst sends `count` words in entry order. Entry i uses register field i of `req_burst_addr` (bits 6i+5:6i). Burst read (op 5) places word i in `burst_rdata[24i+23:24i]`. Burst write (op 6) sends data field i of `req_burst_data`.
- R9: A burst is rejected with an error and no serial activity in any of these cases:
  - count is 0;
  - count exceeds MAX_BURST;
  - any entry below count names a register at or above NUM_REGS.

  Entries at or beyond count are ignored.
- R10: `req_ready` is low from the cycle after acceptance until the operation ends, covering both halves of a read-modify-write. `done_valid` is a one-cycle pulse for each accepted request.
- R11: Opcode 7 is rejected with an error and no serial activity. Opcodes are: 0 read, 1 write, 2 set, 3 clear, 4 masked, 5 burst read, 6 burst write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_op | input | 3 | Operation code |
| req_addr | input | 6 | Register number for single and read-modify-write requests |
| req_data | input | 24 | Write data, or bit pattern for set and clear |
| req_mask | input | 24 | Mask for the masked update |
| req_count | input | $clog2(MAX_BURST+1) | Number of burst entries |
| req_burst_addr | input | 6*MAX_BURST | Register number per burst entry |
| req_burst_data | input | 24*MAX_BURST | Write data per burst entry |
| done_valid | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Request rejected or a read failed |
| done_data | output | 24 | Read data or old value |
| burst_rdata | output | 24*MAX_BURST | Words returned by a burst read |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_cs | output | 1 | Active-high select |
| spi_miso | input | 1 | Serial data in |

## Verification
The bench targets three groups of corner cases.

- **Read-modify-write error path.** A peripheral that floats MISO high must stop a read-modify-write after its first word. A design that still sent the write would leave a second word in the frame log.
- **Range checks.** These are tested on both sides of the boundary: register NUM_REGS-1 is accepted and NUM_REGS is rejected. For bursts, a count of 0, a count above MAX_BURST, and one bad entry among good ones are each tried. Leaking a partial burst, or checking entries past count, would show up as extra frames or as a wrongly rejected request.
- **Select gap and frame layout.** Burst traffic is counted by select rising edges and select-high cycles. A select held high across a burst, a word with a bad bit 24, or merge logic that swapped the mask terms would each change a logged word or a modelled register.

// File: rtl/spi_regmaster_pkg.sv
package spi_regmaster_pkg;
  // Word layout is fixed by the peripheral protocol.
  localparam int FRAME_W = 32;
  localparam int ADDR_W  = 6;
  localparam int DATA_W  = 24;

  localparam logic [2:0] OP_READ  = 3'd0;
  localparam logic [2:0] OP_WRITE = 3'd1;
  localparam logic [2:0] OP_SET   = 3'd2;
  localparam logic [2:0] OP_CLR   = 3'd3;
  localparam logic [2:0] OP_MASK  = 3'd4;
  localparam logic [2:0] OP_BRD   = 3'd5;
  localparam logic [2:0] OP_BWR   = 3'd6;

  typedef enum logic [1:0] {ST_IDLE, ST_LAUNCH, ST_WAIT, ST_FIN} st_e;

  function automatic logic [FRAME_W-1:0] pack_frame(input logic wr,
                                                    input logic [ADDR_W-1:0] a,
                                                    input logic [DATA_W-1:0] d);
    return {wr, a, 1'b0, (wr ? d : {DATA_W{1'b0}})};
  endfunction
endpackage

// File: rtl/spi_word_engine.sv
module spi_word_engine #(
  parameter int FRAME_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [FRAME_W-1:0] tx,
  input  logic               miso,
  output logic               done,
  output logic [FRAME_W-1:0] rx,
  output logic               sclk,
  output logic               mosi,
  output logic               cs
);
  localparam int BIT_W = $clog2(FRAME_W);

  logic               active;
  logic [1:0]         ph;     // four system clocks per serial bit
  logic [BIT_W-1:0]   bitn;
  logic [FRAME_W-1:0] sh;
  logic [FRAME_W-1:0] rxs;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      ph     <= '0;
      bitn   <= '0;
      sh     <= '0;
      rxs    <= '0;
      rx     <= '0;
      done   <= 1'b0;
      sclk   <= 1'b0;
      mosi   <= 1'b0;
      cs     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (start) begin
          active <= 1'b1;
          cs     <= 1'b1;
          sh     <= tx;
          mosi   <= tx[FRAME_W-1];
          ph     <= '0;
          bitn   <= BIT_W'(FRAME_W-1);
        end
      end else begin
        ph <= ph + 2'd1;
        if (ph == 2'd1) begin
          sclk <= 1'b1;
          rxs  <= {rxs[FRAME_W-2:0], miso};
        end
        if (ph == 2'd3) begin
          sclk <= 1'b0;
          if (bitn == '0) begin
            active <= 1'b0;
            cs     <= 1'b0;
            done   <= 1'b1;
            rx     <= rxs;
          end else begin
            bitn <= bitn - 1'b1;
            sh   <= {sh[FRAME_W-2:0], 1'b0};
            mosi <= sh[FRAME_W-2];
          end
        end
      end
    end
  end

  // R2: serial clock pulses only inside a selected word
  a_r2_sclk_in_cs: assert property (@(posedge clk) disable iff (rst)
    sclk |-> cs);
  // R2: select stays low for at least one cycle after each word
  a_r2_cs_gap: assert property (@(posedge clk) disable iff (rst)
    $fell(cs) |=> !cs);
  // R2: data out moves only together with a falling serial clock
  a_r2_mosi_on_fall: assert property (@(posedge clk) disable iff (rst)
    (cs && $past(cs) && !$stable(mosi)) |-> $fell(sclk));
endmodule

// File: rtl/spi_addr_check.sv
module spi_addr_check
  import spi_regmaster_pkg::*;
#(
  parameter int NUM_REGS  = 64,
  parameter int MAX_BURST = 4,
  parameter int CNT_W     = 3
) (
  input  logic [2:0]                  op,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [CNT_W-1:0]            count,
  input  logic [MAX_BURST*ADDR_W-1:0] burst_addr,
  output logic                        reject
);
  localparam int LIM_I = (NUM_REGS > (1 << ADDR_W)) ? (1 << ADDR_W) : NUM_REGS;
  localparam logic [ADDR_W:0] LIM = (ADDR_W+1)'(LIM_I);

  logic [MAX_BURST-1:0] ent_bad;

  for (genvar i = 0; i < MAX_BURST; i++) begin : g_ent
    assign ent_bad[i] = (CNT_W'(i) < count) &&
                        ({1'b0, burst_addr[i*ADDR_W +: ADDR_W]} >= LIM);
  end

  logic is_burst, single_bad, burst_bad;
  always_comb begin
    is_burst   = (op == OP_BRD) || (op == OP_BWR);
    single_bad = ({1'b0, addr} >= LIM);
    burst_bad  = (count == '0) || (count > CNT_W'(MAX_BURST)) || (|ent_bad);
    if (op > OP_BWR)   reject = 1'b1;
    else if (is_burst) reject = burst_bad;
    else               reject = single_bad;
  end
endmodule

// File: rtl/spi_rmw_merge.sv
module spi_rmw_merge
  import spi_regmaster_pkg::*;
(
  input  logic [2:0]        op,
  input  logic [DATA_W-1:0] old_val,
  input  logic [DATA_W-1:0] arg,
  input  logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] new_val
);
  always_comb begin
    case (op)
      OP_SET:  new_val = old_val | arg;
      OP_CLR:  new_val = old_val & ~arg;
      OP_MASK: new_val = (old_val & ~mask) | (arg & mask);
      default: new_val = old_val;
    endcase
  end
endmodule

// File: rtl/spi_regmaster.sv
module spi_regmaster
  import spi_regmaster_pkg::*;
#(
  parameter int NUM_REGS  = 64,
  parameter int MAX_BURST = 4,
  localparam int CNT_W    = $clog2(MAX_BURST + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [2:0]                  req_op,
  input  logic [5:0]                  req_addr,
  input  logic [23:0]                 req_data,
  input  logic [23:0]                 req_mask,
  input  logic [CNT_W-1:0]            req_count,
  input  logic [MAX_BURST*6-1:0]      req_burst_addr,
  input  logic [MAX_BURST*24-1:0]     req_burst_data,
  output logic                        done_valid,
  output logic                        done_err,
  output logic [23:0]                 done_data,
  output logic [MAX_BURST*24-1:0]     burst_rdata,
  output logic                        spi_sclk,
  output logic                        spi_mosi,
  output logic                        spi_cs,
  input  logic                        spi_miso
);
  localparam int IDX_W = (MAX_BURST > 1) ? $clog2(MAX_BURST) : 1;

  st_e                 state_q;
  logic [2:0]          op_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   data_q, mask_q, wdata_q, res_q;
  logic [CNT_W-1:0]    left_q;
  logic [IDX_W-1:0]    idx_q;
  logic                wr_phase_q, err_q;
  logic [ADDR_W-1:0]   b_addr [MAX_BURST];
  logic [DATA_W-1:0]   b_data [MAX_BURST];
  logic [DATA_W-1:0]   b_rd   [MAX_BURST];

  logic                reject, eng_start, eng_done;
  logic [FRAME_W-1:0]  eng_tx, eng_rx;
  logic [DATA_W-1:0]   merged;
  logic                is_burst, is_rmw, rx_bad, last_entry;

  spi_addr_check #(.NUM_REGS(NUM_REGS), .MAX_BURST(MAX_BURST), .CNT_W(CNT_W)) u_chk (
    .op(req_op), .addr(req_addr), .count(req_count),
    .burst_addr(req_burst_addr), .reject(reject));

  spi_rmw_merge u_merge (
    .op(op_q), .old_val(eng_rx[DATA_W-1:0]), .arg(data_q), .mask(mask_q),
    .new_val(merged));

  spi_word_engine #(.FRAME_W(FRAME_W)) u_eng (
    .clk(clk), .rst(rst), .start(eng_start), .tx(eng_tx), .miso(spi_miso),
    .done(eng_done), .rx(eng_rx), .sclk(spi_sclk), .mosi(spi_mosi), .cs(spi_cs));

  for (genvar i = 0; i < MAX_BURST; i++) begin : g_flat
    assign burst_rdata[i*DATA_W +: DATA_W] = b_rd[i];
  end

  always_comb begin
    is_burst   = (op_q == OP_BRD) || (op_q == OP_BWR);
    is_rmw     = (op_q == OP_SET) || (op_q == OP_CLR) || (op_q == OP_MASK);
    rx_bad     = &eng_rx;
    last_entry = (left_q == CNT_W'(1));
    eng_start  = (state_q == ST_LAUNCH);
    req_ready  = (state_q == ST_IDLE);
    if (op_q == OP_BWR)
      eng_tx = pack_frame(1'b1, b_addr[idx_q], b_data[idx_q]);
    else if (op_q == OP_BRD)
      eng_tx = pack_frame(1'b0, b_addr[idx_q], '0);
    else if (wr_phase_q)
      eng_tx = pack_frame(1'b1, addr_q, wdata_q);
    else
      eng_tx = pack_frame(op_q == OP_WRITE, addr_q, data_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      op_q       <= OP_READ;
      addr_q     <= '0;
      data_q     <= '0;
      mask_q     <= '0;
      wdata_q    <= '0;
      res_q      <= '0;
      left_q     <= '0;
      idx_q      <= '0;
      wr_phase_q <= 1'b0;
      err_q      <= 1'b0;
      done_valid <= 1'b0;
      done_err   <= 1'b0;
      done_data  <= '0;
      for (int i = 0; i < MAX_BURST; i++) begin
        b_addr[i] <= '0;
        b_data[i] <= '0;
        b_rd[i]   <= '0;
      end
    end else begin
      done_valid <= 1'b0;
      case (state_q)
        ST_IDLE: if (req_valid) begin
          op_q       <= req_op;
          addr_q     <= req_addr;
          data_q     <= req_data;
          mask_q     <= req_mask;
          left_q     <= req_count;
          idx_q      <= '0;
          wr_phase_q <= 1'b0;
          err_q      <= reject;
          res_q      <= '0;
          for (int i = 0; i < MAX_BURST; i++) begin
            b_addr[i] <= req_burst_addr[i*ADDR_W +: ADDR_W];
            b_data[i] <= req_burst_data[i*DATA_W +: DATA_W];
          end
          state_q <= reject ? ST_FIN : ST_LAUNCH;
        end
        ST_LAUNCH: state_q <= ST_WAIT;
        ST_WAIT: if (eng_done) begin
          if (is_burst) begin
            if (op_q == OP_BRD) begin
              b_rd[idx_q] <= eng_rx[DATA_W-1:0];
              err_q       <= err_q | rx_bad;
            end
            if (last_entry) state_q <= ST_FIN;
            else begin
              idx_q   <= idx_q + 1'b1;
              left_q  <= left_q - 1'b1;
              state_q <= ST_LAUNCH;
            end
          end else if (is_rmw && !wr_phase_q) begin
            res_q <= eng_rx[DATA_W-1:0];
            if (rx_bad) begin
              err_q   <= 1'b1;
              state_q <= ST_FIN;
            end else begin
              wdata_q    <= merged;
              wr_phase_q <= 1'b1;
              state_q    <= ST_LAUNCH;
            end
          end else begin
            if (op_q == OP_READ) begin
              res_q <= eng_rx[DATA_W-1:0];
              err_q <= rx_bad;
            end
            state_q <= ST_FIN;
          end
        end
        ST_FIN: begin
          done_valid <= 1'b1;
          done_err   <= err_q;
          done_data  <= res_q;
          state_q    <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R10: an accepted request holds the port busy on the following cycle
  a_r10_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  // R10: completion is a single-cycle pulse
  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> !done_valid);
  // R6: a failed read half ends the request without a write word
  a_r6_abort_on_error: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT && eng_done && is_rmw && !wr_phase_q && rx_bad)
      |=> (state_q == ST_FIN));
endmodule

// File: tb/spi_regmaster_bench.sv
module spi_regmaster_bench;
  localparam int NREG = 40;
  localparam int MB   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [2:0]    req_op = '0;
  logic [5:0]    req_addr = '0;
  logic [23:0]   req_data = '0, req_mask = '0;
  logic [2:0]    req_count = '0;
  logic [MB*6-1:0]  req_burst_addr = '0;
  logic [MB*24-1:0] req_burst_data = '0;
  logic          done_valid, done_err;
  logic [23:0]   done_data;
  logic [MB*24-1:0] burst_rdata;
  logic          spi_sclk, spi_mosi, spi_cs;
  logic          spi_miso = 1'b0;

  spi_regmaster #(.NUM_REGS(NREG), .MAX_BURST(MB)) u_spi_regmaster (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .req_mask(req_mask),
    .req_count(req_count), .req_burst_addr(req_burst_addr),
    .req_burst_data(req_burst_data), .done_valid(done_valid), .done_err(done_err),
    .done_data(done_data), .burst_rdata(burst_rdata), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_cs(spi_cs), .spi_miso(spi_miso));

  // Peripheral model
  logic [23:0] mem [64];
  bit          absent = 1'b0;
  int          k = 0;
  logic [31:0] rcv = '0;
  logic [5:0]  addr_l = '0;
  logic [31:0] frames [16];
  int nframes = 0, ncs_rise = 0, nsclk_rise = 0, cs_cycles = 0;

  function automatic logic drive_bit(input int idx, input logic [5:0] a);
    if (absent) return 1'b1;
    if (idx >= 24) return 1'b0;
    return mem[a][idx];
  endfunction

  always @(posedge spi_cs) begin
    k = 31; rcv = '0; ncs_rise++;
    spi_miso = drive_bit(31, 6'd0);
  end
  always @(posedge spi_sclk) begin
    rcv = {rcv[30:0], spi_mosi};
    nsclk_rise++;
  end
  always @(negedge spi_sclk) if (spi_cs === 1'b1) begin
    k = k - 1;
    if (k == 23) addr_l = rcv[6:1];
    if (k >= 0) spi_miso = drive_bit(k, addr_l);
  end
  always @(negedge spi_cs) begin
    if (nframes < 16) frames[nframes] = rcv;
    nframes++;
    if (rcv[31] === 1'b1) mem[rcv[30:25]] = rcv[23:0];
  end
  always @(posedge clk) if (spi_cs === 1'b1) cs_cycles++;

  int checks = 0, failures = 0, cyc = 0;
  logic        r_err;
  logic [23:0] r_data;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog R10 actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_log();
    nframes = 0; ncs_rise = 0; nsclk_rise = 0; cs_cycles = 0;
  endtask

  task automatic do_op(input logic [2:0] op, input logic [5:0] a,
                       input logic [23:0] d, input logic [23:0] m,
                       input logic [2:0] cnt);
    @(negedge clk);
    clear_log();
    req_op = op; req_addr = a; req_data = d; req_mask = m; req_count = cnt;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 ready low while busy", {31'd0, req_ready}, 32'd0);
    while (!done_valid) @(negedge clk);
    r_err = done_err; r_data = done_data;
    @(negedge clk);
    chk("R10 done one cycle", {31'd0, done_valid}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R10 ready after reset", {31'd0, req_ready}, 32'd1);
    chk("R2 cs idle low", {31'd0, spi_cs}, 32'd0);
    chk("R2 sclk idle low", {31'd0, spi_sclk}, 32'd0);
    chk("R10 no done at reset", {31'd0, done_valid}, 32'd0);
  endtask

  task automatic t_write();
    do_op(3'd1, 6'd5, 24'hABCDEF, 24'h0, 3'd0);
    chk("R4 write no error", {31'd0, r_err}, 32'd0);
    chk("R4 write result zero", {8'd0, r_data}, 32'd0);
    chk("R1 write frame", frames[0], 32'h8AABCDEF);
    chk("R4 one frame", nframes, 1);
    chk("R4 register written", {8'd0, mem[5]}, 32'h00ABCDEF);
    chk("R2 cs high 128 cycles", cs_cycles, 128);
    chk("R2 32 sclk rises", nsclk_rise, 32);
  endtask

  task automatic t_read();
    mem[9] = 24'h123456;
    do_op(3'd0, 6'd9, 24'hFFFFFF, 24'h0, 3'd0);
    chk("R1 read frame data bits zero", frames[0], 32'h12000000);
    chk("R3 read data", {8'd0, r_data}, 32'h00123456);
    chk("R3 read no error", {31'd0, r_err}, 32'd0);
    absent = 1'b1;
    do_op(3'd0, 6'd3, 24'h0, 24'h0, 3'd0);
    absent = 1'b0;
    chk("R3 all-ones read is error", {31'd0, r_err}, 32'd1);
  endtask

  task automatic t_rmw();
    mem[7] = 24'h0F0F00;
    do_op(3'd2, 6'd7, 24'h000FF0, 24'h0, 3'd0);
    chk("R5 set frames", nframes, 2);
    chk("R5 set read frame", frames[0], 32'h0E000000);
    chk("R5 set write frame", frames[1], 32'h8E0F0FF0);
    chk("R5 set old value", {8'd0, r_data}, 32'h000F0F00);
    do_op(3'd3, 6'd7, 24'h0000F0, 24'h0, 3'd0);
    chk("R5 clear result", {8'd0, mem[7]}, 32'h000F0F00);
    chk("R5 clear old value", {8'd0, r_data}, 32'h000F0FF0);
    mem[10] = 24'hAAAAAA;
    do_op(3'd4, 6'd10, 24'h555555, 24'h00FFFF, 3'd0);
    chk("R5 masked result", {8'd0, mem[10]}, 32'h00AA5555);
    chk("R5 masked old value", {8'd0, r_data}, 32'h00AAAAAA);
    chk("R5 masked no error", {31'd0, r_err}, 32'd0);
  endtask

  task automatic t_rmw_err();
    mem[2] = 24'h000111;
    absent = 1'b1;
    do_op(3'd2, 6'd2, 24'hF00000, 24'h0, 3'd0);
    absent = 1'b0;
    chk("R6 error flag", {31'd0, r_err}, 32'd1);
    chk("R6 only read frame", nframes, 1);
    chk("R6 frame is a read", {31'd0, frames[0][31]}, 32'd0);
    chk("R6 register untouched", {8'd0, mem[2]}, 32'h00000111);
  endtask

  task automatic t_range();
    mem[39] = 24'h0;
    do_op(3'd0, 6'd45, 24'h0, 24'h0, 3'd0);
    chk("R7 read out of range error", {31'd0, r_err}, 32'd1);
    chk("R7 no frames", nframes + ncs_rise, 0);
    do_op(3'd1, 6'd40, 24'h777777, 24'h0, 3'd0);
    chk("R7 write at limit error", {31'd0, r_err}, 32'd1);
    chk("R7 no frames at limit", nframes + nsclk_rise, 0);
    do_op(3'd1, 6'd39, 24'h777777, 24'h0, 3'd0);
    chk("R7 last register ok", {31'd0, r_err}, 32'd0);
    chk("R7 last register written", {8'd0, mem[39]}, 32'h00777777);
  endtask

  task automatic t_burst();
    req_burst_addr = {6'd0, 6'd3, 6'd2, 6'd1};
    req_burst_data = {24'h0, 24'h333333, 24'h222222, 24'h111111};
    do_op(3'd6, 6'd0, 24'h0, 24'h0, 3'd3);
    chk("R8 burst write frames", nframes, 3);
    chk("R8 burst entry 0", frames[0], 32'h82111111);
    chk("R8 burst entry 2", frames[2], 32'h86333333);
    chk("R2 cs drops between words", ncs_rise, 3);
    chk("R2 cs high cycles", cs_cycles, 384);
    chk("R8 mem entry 1", {8'd0, mem[2]}, 32'h00222222);
    mem[0] = 24'hC0FFEE;
    req_burst_addr = {6'd0, 6'd2, 6'd1, 6'd3};
    do_op(3'd5, 6'd0, 24'h0, 24'h0, 3'd4);
    chk("R8 burst read frames", nframes, 4);
    chk("R8 rd word0", {8'd0, burst_rdata[23:0]}, 32'h00333333);
    chk("R8 rd word1", {8'd0, burst_rdata[47:24]}, 32'h00111111);
    chk("R8 rd word3", {8'd0, burst_rdata[95:72]}, 32'h00C0FFEE);
    chk("R8 rd no error", {31'd0, r_err}, 32'd0);
  endtask

  task automatic t_burst_bad();
    req_burst_addr = {6'd0, 6'd50, 6'd2, 6'd1};
    req_burst_data = {4{24'h5A5A5A}};
    do_op(3'd6, 6'd0, 24'h0, 24'h0, 3'd3);
    chk("R9 bad entry rejects", {31'd0, r_err}, 32'd1);
    chk("R9 no frames", nframes + ncs_rise, 0);
    chk("R9 good entry untouched", {8'd0, mem[1]}, 32'h00111111);
    do_op(3'd5, 6'd0, 24'h0, 24'h0, 3'd0);
    chk("R9 zero count rejects", {31'd0, r_err}, 32'd1);
    do_op(3'd5, 6'd0, 24'h0, 24'h0, 3'd5);
    chk("R9 over max rejects", {31'd0, r_err}, 32'd1);
    chk("R9 over max no frames", nframes, 0);
    req_burst_addr = {6'd63, 6'd2, 6'd1, 6'd3};
    do_op(3'd5, 6'd0, 24'h0, 24'h0, 3'd3);
    chk("R9 entry past count ignored", {31'd0, r_err}, 32'd0);
    chk("R9 three frames", nframes, 3);
  endtask

  task automatic t_badop();
    do_op(3'd7, 6'd1, 24'h0, 24'h0, 3'd1);
    chk("R11 opcode 7 error", {31'd0, r_err}, 32'd1);
    chk("R11 no frames", nframes + ncs_rise, 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write();
    t_read();
    t_rmw();
    t_rmw_err();
    t_range();
    t_burst();
    t_burst_bad();
    t_badop();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule